// File: doc/BRIEF.md
# Sleep and Wake Power Sequencer

This controller moves a small sensor node between a fully powered working state and a deep sleep state. It drives the strobes that open or block memory access, clamp the isolation cells, switch the power gate of the processor and scratch memory, set the power-management unit's mode, pick the rate of the switched-capacitor converter clock, and enable the linear regulator. Each transition follows a fixed order. Going down, memory access is blocked before any domain is gated. Coming up, the regulator and the fast converter clock are running before the gate opens.

The processor asks for sleep by raising a level request, and the block answers with a one-cycle acknowledge. At that moment a down-counter is loaded from a writable interval register. While the node sleeps, the counter steps once per pulse of a slow tick enable, and the node wakes when the count is used up. On wake, a settle counter sized by a parameter must run out before the power gate is released. Two retained registers hold a program pointer and a storage pointer. They can be written only while the processor is fully powered, and they keep their values through any number of sleep periods.

Top module: `slumber_sequencer`

## Requirements
- R1: After reset, the block is active: sramEn=1, isoEn=0, pwrGate=0, pmuSleep=0, clkFast=1, ldoEn=1, sleepAck=0. Both pointers read 0.
- R2: When sleepReq is sampled high in the active state, sleepAck is high for exactly one cycle, in the cycle after the sampling edge. sramEn drops to 0 in that same cycle.
- R3: The entry order is fixed. One cycle after the acknowledge, isoEn rises. The next cycle, pwrGate rises. The cycle after that, pmuSleep=1, clkFast=0 and ldoEn=0.
- R4: slowTick is counted only in the sleep state, and is ignored at all other times. The edge that samples the Nth tick of a sleep moves the block to wake, where N = max(interval,1). In the wake state, pmuSleep=0, clkFast=1, ldoEn=1, and pwrGate and isoEn stay at 1.
- R5: From the first wake cycle, pwrGate stays at 1 for SETTLE_CYC+1 cycles and then falls.
- R6: isoEn falls one cycle after pwrGate falls. sramEn rises one cycle after that, which completes the return to active.
- R7: A sleepReq held high during a wake sequence is not acknowledged early. The acknowledge comes one cycle after sramEn returns to 1.
- R8: intervalIn is written into the interval register whenever intervalWe is high, and the reset value is INTERVAL_RST. The register is copied into the timer only at sleep acceptance, so a write made during a sleep does not change the length of that sleep.
- R9: A write to progPtr and storePtr through ptrWe takes effect only in the active state, including the cycle in which a sleep request is accepted. It is visible one cycle later. A write at any other time is ignored. The values persist across sleep periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slowTick | input | 1 | Slow timer enable pulse |
| sleepReq | input | 1 | Sleep request from the processor (level) |
| sleepAck | output | 1 | One-cycle acknowledge of the sleep request |
| intervalWe | input | 1 | Write strobe for the sleep interval |
| intervalIn | input | TIMER_W | New sleep interval in slow ticks |
| ptrWe | input | 1 | Write strobe for both retained pointers |
| progPtrIn | input | PTR_W | New program pointer |
| storePtrIn | input | PTR_W | New storage pointer |
| progPtr | output | PTR_W | Retained program pointer |
| storePtr | output | PTR_W | Retained storage pointer |
| sramEn | output | 1 | Memory accesses allowed |
| isoEn | output | 1 | Isolation clamps on |
| pwrGate | output | 1 | Processor and scratch memory gated off |
| pmuSleep | output | 1 | Power-management unit in sleep mode |
| clkFast | output | 1 | Converter clock select, 1 = fast rate |
| ldoEn | output | 1 | Linear regulator enable |

## Verification
Two pairs of events can fall in the same cycle. A pointer write can coincide with the acceptance of a sleep request. A sleep request held through a wake sequence meets the first fully active cycle. The bench raises ptrWe together with sleepReq and expects both the acknowledge and the new pointer values. It also keeps sleepReq high from the middle of a sleep through the whole wake sequence. A scoreboard then checks every cycle of the wake vector sequence, expects no acknowledge before sramEn returns, and expects the acknowledge exactly one cycle later.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [3:0] {
    ST_ACTIVE,
    ST_BLOCK,
    ST_ISO,
    ST_GATE,
    ST_SLEEP,
    ST_WAKE,
    ST_UNGATE,
    ST_UNISO
  } seqState_t;

  typedef struct packed {
    logic timerLoad;
    logic timerDec;
    logic settleLoad;
    logic settleDec;
    logic ptrOpen;
  } seqStrobes_t;

endpackage

// File: rtl/slp_datapath.sv
module slp_datapath
  import slp_pkg::*;
#(
  parameter int TIMER_W      = 16,
  parameter int PTR_W        = 16,
  parameter int SETTLE_CYC   = 5,
  parameter int INTERVAL_RST = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seqStrobes_t        strb,
  input  logic               intervalWe,
  input  logic [TIMER_W-1:0] intervalIn,
  input  logic               ptrWe,
  input  logic [PTR_W-1:0]   progPtrIn,
  input  logic [PTR_W-1:0]   storePtrIn,
  output logic [PTR_W-1:0]   progPtr,
  output logic [PTR_W-1:0]   storePtr,
  output logic               timerLast,
  output logic               settleDone
);

  localparam int SW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

  logic [TIMER_W-1:0] intervalReg;
  logic [TIMER_W-1:0] timerCnt;
  logic [SW-1:0]      settleCnt;

  // interval register, writable at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intervalReg <= TIMER_W'(INTERVAL_RST);
    else if (intervalWe) intervalReg <= intervalIn;
  end

  // sleep timer: loaded at acceptance, stepped on slow ticks while asleep
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timerCnt <= '0;
    else if (strb.timerLoad) timerCnt <= intervalReg;
    else if (strb.timerDec) timerCnt <= timerCnt - 1'b1;
  end

  assign timerLast = (timerCnt <= TIMER_W'(1));

  // settle counter for the regulator ramp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settleCnt <= '0;
    else if (strb.settleLoad) settleCnt <= SW'(SETTLE_CYC);
    else if (strb.settleDec) settleCnt <= settleCnt - 1'b1;
  end

  assign settleDone = (settleCnt == '0);

  // retained pointers, written only while the core is live
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      progPtr  <= '0;
      storePtr <= '0;
    end else if (ptrWe && strb.ptrOpen) begin
      progPtr  <= progPtrIn;
      storePtr <= storePtrIn;
    end
  end

  // R9: pointers hold unless a live write occurs
  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptrWe && strb.ptrOpen) |=> ($stable(progPtr) && $stable(storePtr)));

  // R4: timer does not move without a strobe
  a_r4_timer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.timerLoad && !strb.timerDec) |=> $stable(timerCnt));

  // R4: load and step never coincide
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.timerLoad && strb.timerDec));

endmodule

// File: rtl/slp_control.sv
module slp_control
  import slp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleepReq,
  input  logic        slowTick,
  input  logic        timerLast,
  input  logic        settleDone,
  output seqStrobes_t strb,
  output logic        sleepAck,
  output logic        sramEn,
  output logic        isoEn,
  output logic        pwrGate,
  output logic        pmuSleep,
  output logic        clkFast,
  output logic        ldoEn
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ACTIVE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_ACTIVE: if (sleepReq) nextState = ST_BLOCK;
      ST_BLOCK:  nextState = ST_ISO;
      ST_ISO:    nextState = ST_GATE;
      ST_GATE:   nextState = ST_SLEEP;
      ST_SLEEP:  if (slowTick && timerLast) nextState = ST_WAKE;
      ST_WAKE:   if (settleDone) nextState = ST_UNGATE;
      ST_UNGATE: nextState = ST_UNISO;
      ST_UNISO:  nextState = ST_ACTIVE;
      default:   nextState = ST_ACTIVE;
    endcase
  end

  always_comb begin
    strb.timerLoad  = (state == ST_ACTIVE) && sleepReq;
    strb.timerDec   = (state == ST_SLEEP) && slowTick && !timerLast;
    strb.settleLoad = (state == ST_SLEEP) && slowTick && timerLast;
    strb.settleDec  = (state == ST_WAKE) && !settleDone;
    strb.ptrOpen    = (state == ST_ACTIVE);
  end

  // output decode per state
  always_comb begin
    sleepAck = 1'b0;
    sramEn   = 1'b0;
    isoEn    = 1'b1;
    pwrGate  = 1'b1;
    pmuSleep = 1'b0;
    clkFast  = 1'b1;
    ldoEn    = 1'b1;
    unique case (state)
      ST_ACTIVE: begin sramEn = 1'b1; isoEn = 1'b0; pwrGate = 1'b0; end
      ST_BLOCK:  begin sleepAck = 1'b1; isoEn = 1'b0; pwrGate = 1'b0; end
      ST_ISO:    pwrGate = 1'b0;
      ST_GATE:   ;
      ST_SLEEP:  begin pmuSleep = 1'b1; clkFast = 1'b0; ldoEn = 1'b0; end
      ST_WAKE:   ;
      ST_UNGATE: pwrGate = 1'b0;
      ST_UNISO:  begin isoEn = 1'b0; pwrGate = 1'b0; end
      default:   ;
    endcase
  end

  // R2: acknowledge is a single-cycle pulse
  a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sleepAck |=> !sleepAck);

  // R3: gating only after memory is blocked and clamps are on
  a_r3_gate_after_block: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrGate) |-> (isoEn && !sramEn));

  // R3: sleep mode only with everything else already safe
  a_r3_sleep_safe: assert property (@(posedge clk) disable iff (!rst_n)
    pmuSleep |-> (pwrGate && isoEn && !sramEn && !clkFast && !ldoEn));

  // R5: ungating only with regulator and fast clock running
  a_r5_ungate_powered: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwrGate) |-> (ldoEn && clkFast && !pmuSleep && isoEn));

  // R6: clamps released only after ungating
  a_r6_iso_after_ungate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(isoEn) |-> !pwrGate);

  // R6: memory reopened only once clamps are off
  a_r6_sram_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sramEn) |-> (!isoEn && !pwrGate));

endmodule

// File: rtl/slumber_sequencer.sv
module slumber_sequencer
  import slp_pkg::*;
#(
  parameter int TIMER_W      = 16,
  parameter int PTR_W        = 16,
  parameter int SETTLE_CYC   = 5,
  parameter int INTERVAL_RST = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slowTick,
  input  logic               sleepReq,
  output logic               sleepAck,
  input  logic               intervalWe,
  input  logic [TIMER_W-1:0] intervalIn,
  input  logic               ptrWe,
  input  logic [PTR_W-1:0]   progPtrIn,
  input  logic [PTR_W-1:0]   storePtrIn,
  output logic [PTR_W-1:0]   progPtr,
  output logic [PTR_W-1:0]   storePtr,
  output logic               sramEn,
  output logic               isoEn,
  output logic               pwrGate,
  output logic               pmuSleep,
  output logic               clkFast,
  output logic               ldoEn
);

  seqStrobes_t strb;
  logic        timerLast;
  logic        settleDone;

  slp_control i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleepReq   (sleepReq),
    .slowTick   (slowTick),
    .timerLast  (timerLast),
    .settleDone (settleDone),
    .strb       (strb),
    .sleepAck   (sleepAck),
    .sramEn     (sramEn),
    .isoEn      (isoEn),
    .pwrGate    (pwrGate),
    .pmuSleep   (pmuSleep),
    .clkFast    (clkFast),
    .ldoEn      (ldoEn)
  );

  slp_datapath #(
    .TIMER_W      (TIMER_W),
    .PTR_W        (PTR_W),
    .SETTLE_CYC   (SETTLE_CYC),
    .INTERVAL_RST (INTERVAL_RST)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .intervalWe (intervalWe),
    .intervalIn (intervalIn),
    .ptrWe      (ptrWe),
    .progPtrIn  (progPtrIn),
    .storePtrIn (storePtrIn),
    .progPtr    (progPtr),
    .storePtr   (storePtr),
    .timerLast  (timerLast),
    .settleDone (settleDone)
  );

endmodule

// File: tb/test_slumber_sequencer.sv
module test_slumber_sequencer;

  localparam int TW = 16;
  localparam int PW = 16;
  localparam int S  = 5;
  localparam int IRST = 4;

  // vector order {ack, sram, iso, gate, pmu, fast, ldo}
  localparam logic [6:0] V_ACT   = 7'b0100011;
  localparam logic [6:0] V_ACK   = 7'b1000011;
  localparam logic [6:0] V_ISO   = 7'b0010011;
  localparam logic [6:0] V_GATE  = 7'b0011011;
  localparam logic [6:0] V_SLP   = 7'b0011100;
  localparam logic [6:0] V_WAKE  = 7'b0011011;
  localparam logic [6:0] V_UNG   = 7'b0010011;
  localparam logic [6:0] V_UNISO = 7'b0000011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slowTick = 1'b0, sleepReq = 1'b0, intervalWe = 1'b0, ptrWe = 1'b0;
  logic [TW-1:0] intervalIn = '0;
  logic [PW-1:0] progPtrIn = '0, storePtrIn = '0;
  logic sleepAck, sramEn, isoEn, pwrGate, pmuSleep, clkFast, ldoEn;
  logic [PW-1:0] progPtr, storePtr;

  int cyc = 0;
  int nVec = 0;
  int nBad = 0;

  typedef struct {
    int         at;
    logic [6:0] v;
    string      tag;
  } item_t;

  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  slumber_sequencer #(
    .TIMER_W(TW), .PTR_W(PW), .SETTLE_CYC(S), .INTERVAL_RST(IRST)
  ) i_slumber_sequencer (
    .clk(clk), .rst_n(rst_n), .slowTick(slowTick), .sleepReq(sleepReq),
    .sleepAck(sleepAck), .intervalWe(intervalWe), .intervalIn(intervalIn),
    .ptrWe(ptrWe), .progPtrIn(progPtrIn), .storePtrIn(storePtrIn),
    .progPtr(progPtr), .storePtr(storePtr), .sramEn(sramEn), .isoEn(isoEn),
    .pwrGate(pwrGate), .pmuSleep(pmuSleep), .clkFast(clkFast), .ldoEn(ldoEn)
  );

  function automatic logic [6:0] outVec();
    return {sleepAck, sramEn, isoEn, pwrGate, pmuSleep, clkFast, ldoEn};
  endfunction

  task automatic push(input int at, input logic [6:0] v, input string tag);
    item_t it;
    it.at = at; it.v = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic checkPtr(input logic [PW-1:0] ep, input logic [PW-1:0] es, input string tag);
    nVec++;
    if (progPtr !== ep || storePtr !== es) begin
      nBad++;
      $display("FAIL %s pointers got %h/%h expected %h/%h", tag, progPtr, storePtr, ep, es);
    end
  endtask

  // monitor: compares scoreboard items due in the current cycle
  always @(negedge clk) begin
    item_t it;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      it = sb.pop_front();
      nVec++;
      if (it.at != cyc || outVec() !== it.v) begin
        nBad++;
        $display("FAIL %s cycle %0d got %b expected %b (due %0d)", it.tag, cyc, outVec(), it.v, it.at);
      end
    end
  end

  // called at a negedge in the active state
  task automatic enterSleep();
    int n;
    n = cyc;
    sleepReq = 1'b1;
    push(n + 1, V_ACK, "R2");
    push(n + 2, V_ISO, "R3");
    push(n + 3, V_GATE, "R3");
    push(n + 4, V_SLP, "R3");
    @(negedge clk);
    sleepReq = 1'b0;
    ptrWe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // called at a negedge in the sleep state
  task automatic wakeBy(input int ticks, input int gap, input bit hold);
    int m;
    if (hold) sleepReq = 1'b1;
    for (int i = 0; i < ticks; i++) begin
      push(cyc + 1, (i == ticks - 1) ? V_WAKE : V_SLP, "R4");
      slowTick = 1'b1;
      @(negedge clk);
      slowTick = 1'b0;
      if (i != ticks - 1) begin
        for (int g = 0; g < gap; g++) begin
          push(cyc + 1, V_SLP, "R4");
          @(negedge clk);
        end
      end
    end
    m = cyc;  // first wake cycle
    for (int k = 1; k <= S; k++) push(m + k, V_WAKE, "R5");
    push(m + S + 1, V_UNG, "R5");
    push(m + S + 2, V_UNISO, "R6");
    push(m + S + 3, V_ACT, hold ? "R7" : "R6");
    repeat (S + 3) @(negedge clk);
    if (hold) enterSleep();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    nVec++;
    if (outVec() !== V_ACT) begin
      nBad++;
      $display("FAIL R1 reset outputs got %b expected %b", outVec(), V_ACT);
    end
    checkPtr('0, '0, "R1");

    // R4: ticks while active are ignored
    for (int i = 0; i < 3; i++) begin
      push(cyc + 1, V_ACT, "R4");
      slowTick = 1'b1;
      @(negedge clk);
    end
    slowTick = 1'b0;
    @(negedge clk);

    // R8 default interval, R4 spaced ticks
    enterSleep();
    wakeBy(IRST, 2, 1'b0);

    // R8 interval 0 behaves as one tick
    intervalWe = 1'b1; intervalIn = '0;
    @(negedge clk);
    intervalWe = 1'b0;

    // R9 pointer write together with sleep acceptance
    ptrWe = 1'b1; progPtrIn = 16'hA5C3; storePtrIn = 16'h0F1E;
    enterSleep();
    checkPtr(16'hA5C3, 16'h0F1E, "R9");

    // R9 write while asleep is ignored
    ptrWe = 1'b1; progPtrIn = 16'h1111; storePtrIn = 16'h2222;
    @(negedge clk);
    ptrWe = 1'b0;
    @(negedge clk);
    checkPtr(16'hA5C3, 16'h0F1E, "R9");

    // R7 request held through wake, then a new sleep with interval 0
    wakeBy(1, 0, 1'b1);

    // R8 write during sleep does not change this sleep
    intervalWe = 1'b1; intervalIn = 16'd3;
    @(negedge clk);
    intervalWe = 1'b0;
    push(cyc + 1, V_SLP, "R8");
    @(negedge clk);
    wakeBy(1, 0, 1'b0);
    checkPtr(16'hA5C3, 16'h0F1E, "R9");

    // R8 new interval used on next sleep, back-to-back ticks
    enterSleep();
    wakeBy(3, 0, 1'b0);
    checkPtr(16'hA5C3, 16'h0F1E, "R9");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      nBad++;
      $display("FAIL scoreboard %0d items left expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule